// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Word Reader

This block is a synchronous master that fetches one 16-bit word from a small serial EEPROM with a three-wire interface. When it is idle, a one-cycle start request with a word address launches a read. The block raises chip select and shifts out a ten-bit read command, most significant bit first, on the data-in line. It then keeps data-in low and clocks sixteen data bits in from the device's data-out line. Finally it drops chip select, waits out the deselect time and returns the word with a one-cycle done pulse.

Every minimum interval of the serial interface is given in nanoseconds and turned into a count of system clocks from a clock-frequency parameter. The count is rounded up, so a change of system clock only needs a new parameter value. The returned word is also offered as two bytes, in the order the data were received.

Top module: `sereeprom_word_reader`

## Requirements
- R1: The command is ten bits, sent most significant bit first on one rising serial-clock edge each: bit 9 is 0, bits 8 and 7 are 1, bits 6 to 4 are 0 and bits 3 to 0 carry the word address, giving 0x180 OR the address.
- R2: Chip select rises before anything else. The first serial-clock rising edge comes no earlier than the select setup time plus the data setup time after that, and the serial clock is high only while chip select is high.
- R3: Data-in is stable for at least the data setup time before every rising serial-clock edge and does not change while the clock is high.
- R4: Each clock high phase and each clock low phase lasts at least its minimum (1000 ns each), and rising edges are at least the minimum clock period (4000 ns) apart.
- R5: After the command, data-in stays low for sixteen more clock pulses, so one access has exactly 26 rising edges.
- R6: Data-out is sampled at the end of each high phase of the last sixteen pulses, most significant bit first, and the result is presented on the word output.
- R7: After the last bit, chip select falls and stays low for at least the deselect time (1000 ns) before the next access raises it. Done is asserted only after chip select has fallen.
- R8: The first byte output equals word bits 15 to 8 (received first) and the second byte output equals bits 7 to 0.
- R9: Busy rises in the cycle after an accepted start and stays high up to and including the one-cycle done pulse. A start while busy is ignored and does not change the address being read.
- R10: Every minimum time is converted to system clocks by rounding up, with at least one cycle, so no minimum is broken at any clock-frequency parameter.
- R11: Out of reset and whenever idle, chip select, serial clock and data-in are all low and busy is low. A synchronous reset in the middle of an access returns the block to idle in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-cycle read request, taken only when idle |
| addr | input | ADDR_W | Word address sampled with start |
| ee_cs | output | 1 | Chip select to the EEPROM |
| ee_sk | output | 1 | Serial clock to the EEPROM |
| ee_di | output | 1 | Serial data into the EEPROM |
| ee_do | input | 1 | Serial data out of the EEPROM |
| busy | output | 1 | High from accepted start through done |
| done | output | 1 | One-cycle pulse when the word is valid |
| word | output | DATA_W | Word that was read |
| byte_first | output | DATA_W/2 | Upper half of the word, received first |
| byte_second | output | DATA_W/2 | Lower half of the word |

## Verification
A wrong sequencer state or bit index appears at the pins within one serial-clock phase: an extra or missing rising edge, or a command pattern other than 0x180 OR the address, which a device model decodes at the moment chip select falls. A wrong timer load value shows up as a high, low, setup, select or deselect interval shorter than its rounded-up minimum on the first pulse that uses it. To expose rounding faults that would hide at a fast clock, the checks run at two clock-frequency settings. A fault in the receive shifter appears only in the returned word and bytes at done, so each read uses an address whose stored pattern makes a bit-order or off-by-one error visible.

// File: rtl/mwrd_pkg.sv
package mwrd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEL,
    ST_LOW,
    ST_HIGH,
    ST_DESEL,
    ST_DONE
  } mwrd_state_e;

  localparam int unsigned CMD_W = 10;
  localparam logic [CMD_W-1:0] READ_PREFIX = 10'h180;

  // Minimum time in ns to whole clock cycles, rounded up, never below one.
  function automatic int unsigned ns_to_cyc(input longint unsigned ns,
                                            input longint unsigned hz);
    longint unsigned prod;
    longint unsigned q;
    prod = ns * hz;
    q = (prod + 64'd999_999_999) / 64'd1_000_000_000;
    if (q == 64'd0) q = 64'd1;
    return int'(q);
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/mwrd_timer.sv
module mwrd_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired = (cnt_q == '0);

  AST_TIMER_COUNTS_DOWN: assert property (@(posedge clk) disable iff (rst)
    !load && !expired |=> cnt_q == $past(cnt_q) - 1'b1); // R10

endmodule

// File: rtl/mwrd_shift.sv
module mwrd_shift
  import mwrd_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ADDR_W-1:0] addr,
  input  logic              advance,
  input  logic              sample,
  input  logic              ser_in,
  output logic              ser_out,
  output logic [DATA_W-1:0] rx_word
);

  localparam int unsigned TOT_W = CMD_W + DATA_W;

  logic [TOT_W-1:0]  tx_q;
  logic [DATA_W-1:0] rx_q;
  logic [CMD_W-1:0]  cmd_w;

  assign cmd_w = READ_PREFIX | CMD_W'(addr);

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_q <= '0;
      rx_q <= '0;
    end else begin
      if (load) begin
        tx_q <= {cmd_w, {DATA_W{1'b0}}};
        rx_q <= '0;
      end else begin
        if (advance) tx_q <= {tx_q[TOT_W-2:0], 1'b0};
        if (sample)  rx_q <= {rx_q[DATA_W-2:0], ser_in};
      end
    end
  end

  assign ser_out = tx_q[TOT_W-1];
  assign rx_word = rx_q;

  AST_LOAD_PUTS_COMMAND: assert property (@(posedge clk) disable iff (rst)
    load |=> tx_q[TOT_W-1 -: 3] == 3'b011); // R1

endmodule

// File: rtl/mwrd_seq.sv
module mwrd_seq
  import mwrd_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned CNT_W  = 8,
  parameter int unsigned CSS_C  = 2,
  parameter int unsigned LO_C   = 2,
  parameter int unsigned HI_C   = 2,
  parameter int unsigned CSD_C  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             expired,
  output logic             t_load,
  output logic [CNT_W-1:0] t_val,
  output logic             sh_load,
  output logic             sh_adv,
  output logic             sh_sample,
  output logic             cs_o,
  output logic             sk_o,
  output logic             drive_o,
  output logic             busy,
  output logic             done
);

  localparam int unsigned TOT_W = CMD_W + DATA_W;
  localparam int unsigned IDX_W = $clog2(TOT_W);

  mwrd_state_e      state_q, state_n;
  logic [IDX_W-1:0] idx_q;
  logic             last_bit;

  assign last_bit = (idx_q == IDX_W'(TOT_W - 1));

  always_comb begin
    state_n   = state_q;
    t_load    = 1'b0;
    t_val     = '0;
    sh_load   = 1'b0;
    sh_adv    = 1'b0;
    sh_sample = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start) begin
        state_n = ST_SEL;
        t_load  = 1'b1;
        t_val   = CNT_W'(CSS_C - 1);
        sh_load = 1'b1;
      end
      ST_SEL: if (expired) begin
        state_n = ST_LOW;
        t_load  = 1'b1;
        t_val   = CNT_W'(LO_C - 1);
      end
      ST_LOW: if (expired) begin
        state_n = ST_HIGH;
        t_load  = 1'b1;
        t_val   = CNT_W'(HI_C - 1);
      end
      ST_HIGH: if (expired) begin
        sh_adv    = 1'b1;
        sh_sample = (idx_q >= IDX_W'(CMD_W));
        t_load    = 1'b1;
        if (last_bit) begin
          state_n = ST_DESEL;
          t_val   = CNT_W'(CSD_C - 1);
        end else begin
          state_n = ST_LOW;
          t_val   = CNT_W'(LO_C - 1);
        end
      end
      ST_DESEL: if (expired) state_n = ST_DONE;
      ST_DONE:  state_n = ST_IDLE;
      default:  state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      cs_o    <= 1'b0;
      sk_o    <= 1'b0;
      drive_o <= 1'b0;
    end else begin
      state_q <= state_n;
      cs_o    <= (state_n == ST_SEL) || (state_n == ST_LOW) || (state_n == ST_HIGH);
      sk_o    <= (state_n == ST_HIGH);
      drive_o <= (state_n == ST_LOW) || (state_n == ST_HIGH);
      if (sh_load)     idx_q <= '0;
      else if (sh_adv) idx_q <= idx_q + 1'b1;
    end
  end

  assign busy = (state_q != ST_IDLE);
  assign done = (state_q == ST_DONE);

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !cs_o && !sk_o && !drive_o); // R11
  AST_CLOCK_ONLY_SELECTED: assert property (@(posedge clk) disable iff (rst)
    sk_o |-> cs_o); // R2
  AST_START_TAKEN: assert property (@(posedge clk) disable iff (rst)
    start && !busy |=> busy && cs_o); // R9
  AST_BUSY_ENDS_AT_DONE: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> $past(done)); // R9
  AST_DESELECTED_AT_DONE: assert property (@(posedge clk) disable iff (rst)
    done |-> !cs_o && !sk_o); // R7
  AST_SAMPLE_IN_HIGH: assert property (@(posedge clk) disable iff (rst)
    sh_sample |-> sk_o && !drive_o == 1'b0); // R6

endmodule

// File: rtl/sereeprom_word_reader.sv
module sereeprom_word_reader
  import mwrd_pkg::*;
#(
  parameter longint unsigned CLK_HZ   = 50_000_000,
  parameter int unsigned     ADDR_W   = 4,
  parameter int unsigned     DATA_W   = 16,
  parameter int unsigned     T_CSS_NS = 1000,
  parameter int unsigned     T_DIS_NS = 400,
  parameter int unsigned     T_SKH_NS = 1000,
  parameter int unsigned     T_SKL_NS = 1000,
  parameter int unsigned     T_PER_NS = 4000,
  parameter int unsigned     T_CSD_NS = 1000
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start,
  input  logic [ADDR_W-1:0]     addr,
  output logic                  ee_cs,
  output logic                  ee_sk,
  output logic                  ee_di,
  input  logic                  ee_do,
  output logic                  busy,
  output logic                  done,
  output logic [DATA_W-1:0]     word,
  output logic [DATA_W/2-1:0]   byte_first,
  output logic [DATA_W/2-1:0]   byte_second
);

  localparam int unsigned HALF_W = DATA_W / 2;
  localparam int unsigned CSS_C  = ns_to_cyc(T_CSS_NS, CLK_HZ);
  localparam int unsigned DIS_C  = ns_to_cyc(T_DIS_NS, CLK_HZ);
  localparam int unsigned SKH_C  = ns_to_cyc(T_SKH_NS, CLK_HZ);
  localparam int unsigned SKL_C  = ns_to_cyc(T_SKL_NS, CLK_HZ);
  localparam int unsigned PER_C  = ns_to_cyc(T_PER_NS, CLK_HZ);
  localparam int unsigned CSD_C  = ns_to_cyc(T_CSD_NS, CLK_HZ);
  localparam int unsigned HI_C   = max2(SKH_C, (PER_C + 1) / 2);
  localparam int unsigned LO_C   = max2(max2(SKL_C, DIS_C), PER_C - HI_C);
  localparam int unsigned MAX_C  = max2(max2(CSS_C, CSD_C), max2(HI_C, LO_C));
  localparam int unsigned CNT_W  = $clog2(MAX_C + 1);

  logic             t_load;
  logic [CNT_W-1:0] t_val;
  logic             t_exp;
  logic             sh_load;
  logic             sh_adv;
  logic             sh_sample;
  logic             drive;
  logic             tx_bit;

  initial begin
    assert (ADDR_W <= 6 && DATA_W >= 2 && DATA_W % 2 == 0);
  end

  mwrd_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (t_load),
    .load_val (t_val),
    .expired  (t_exp)
  );

  mwrd_seq #(
    .DATA_W (DATA_W),
    .CNT_W  (CNT_W),
    .CSS_C  (CSS_C),
    .LO_C   (LO_C),
    .HI_C   (HI_C),
    .CSD_C  (CSD_C)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .expired   (t_exp),
    .t_load    (t_load),
    .t_val     (t_val),
    .sh_load   (sh_load),
    .sh_adv    (sh_adv),
    .sh_sample (sh_sample),
    .cs_o      (ee_cs),
    .sk_o      (ee_sk),
    .drive_o   (drive),
    .busy      (busy),
    .done      (done)
  );

  mwrd_shift #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_shift (
    .clk     (clk),
    .rst     (rst),
    .load    (sh_load),
    .addr    (addr),
    .advance (sh_adv),
    .sample  (sh_sample),
    .ser_in  (ee_do),
    .ser_out (tx_bit),
    .rx_word (word)
  );

  assign ee_di       = drive & tx_bit;
  assign byte_first  = word[DATA_W-1 -: HALF_W];
  assign byte_second = word[HALF_W-1:0];

  AST_DI_STABLE_WHILE_HIGH: assert property (@(posedge clk) disable iff (rst)
    ee_sk |-> $stable(ee_di)); // R3
  AST_WORD_STEADY_IDLE: assert property (@(posedge clk) disable iff (rst)
    !busy && !$past(busy) |-> $stable(word)); // R6

endmodule

// File: tb/sereeprom_word_reader_tb_top.sv
module mwrd_dev_model (
  input  logic clk,
  input  logic rst,
  input  logic cs,
  input  logic sk,
  input  logic din,
  output logic dout
);
  int min_hi = 1000000, min_lo = 1000000, min_setup = 1000000;
  int min_css = 1000000, min_per = 1000000, min_csd = 1000000;
  int rises = 0, last_rises = 0, n_acc = 0;
  int lvl_run = 0, din_run = 0, cs_run = 0, csl_run = 0, per_run = 0;
  logic seen_fall = 1'b0;
  logic p_cs = 1'b0, p_sk = 1'b0, p_din = 1'b0;
  logic [9:0] cmd = '0, last_cmd = '0;
  logic [15:0] w;

  function automatic logic [15:0] word_of(input logic [3:0] a);
    return 16'h5A3C ^ {a, ~a, a, 4'hF};
  endfunction

  initial dout = 1'b0;

  always @(posedge clk) begin
    if (rst) begin
      rises = 0; seen_fall = 1'b0; dout <= 1'b0;
      p_cs = 1'b0; p_sk = 1'b0; p_din = 1'b0;
      lvl_run = 0; din_run = 0; cs_run = 0; csl_run = 0; per_run = 0;
    end else begin
      if (cs && !p_cs) begin
        if (seen_fall && csl_run < min_csd) min_csd = csl_run;
        rises = 0; cs_run = 0;
      end
      if (!cs && p_cs) begin
        last_cmd = cmd; last_rises = rises; n_acc++;
        seen_fall = 1'b1; csl_run = 0; dout <= 1'b0;
      end
      if (sk && !p_sk) begin
        if (lvl_run < min_lo) min_lo = lvl_run;
        if (din_run < min_setup) min_setup = din_run;
        if (rises == 0) begin
          if (cs_run < min_css) min_css = cs_run;
        end else if (per_run < min_per) min_per = per_run;
        per_run = 0;
        if (rises < 10) cmd = {cmd[8:0], din};
        else if (rises < 26) begin
          w = word_of(cmd[3:0]);
          dout <= w[25-rises];
        end
        rises++;
      end
      if (!sk && p_sk && lvl_run < min_hi) min_hi = lvl_run;
      lvl_run = (sk != p_sk) ? 1 : lvl_run + 1;
      din_run = (din != p_din) ? 1 : din_run + 1;
      per_run++;
      if (cs) cs_run++;
      if (!cs) csl_run++;
      p_cs = cs; p_sk = sk; p_din = din;
    end
  end
endmodule

module sereeprom_word_reader_tb_top;
  localparam longint unsigned HZ_FAST = 50_000_000;
  localparam longint unsigned HZ_SLOW = 3_300_000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sel = 1'b0;
  logic start_req = 1'b0;
  logic [3:0] addr = '0;
  int n_run = 0, n_fail = 0, cyc = 0;

  logic cs0, sk0, di0, do0, busy0, done0;
  logic cs1, sk1, di1, do1, busy1, done1;
  logic [15:0] w0, w1;
  logic [7:0] bf0, bs0, bf1, bs1;

  always #10 clk = ~clk;

  sereeprom_word_reader #(.CLK_HZ(HZ_FAST)) dut_i (
    .clk(clk), .rst(rst), .start(start_req && !sel), .addr(addr),
    .ee_cs(cs0), .ee_sk(sk0), .ee_di(di0), .ee_do(do0),
    .busy(busy0), .done(done0), .word(w0), .byte_first(bf0), .byte_second(bs0));
  sereeprom_word_reader #(.CLK_HZ(HZ_SLOW)) dut_slow (
    .clk(clk), .rst(rst), .start(start_req && sel), .addr(addr),
    .ee_cs(cs1), .ee_sk(sk1), .ee_di(di1), .ee_do(do1),
    .busy(busy1), .done(done1), .word(w1), .byte_first(bf1), .byte_second(bs1));

  mwrd_dev_model p0 (.clk(clk), .rst(rst), .cs(cs0), .sk(sk0), .din(di0), .dout(do0));
  mwrd_dev_model p1 (.clk(clk), .rst(rst), .cs(cs1), .sk(sk1), .din(di1), .dout(do1));

  wire busy_s = sel ? busy1 : busy0;
  wire done_s = sel ? done1 : done0;
  wire [15:0] word_s = sel ? w1 : w0;
  wire [7:0] bf_s = sel ? bf1 : bf0;
  wire [7:0] bs_s = sel ? bs1 : bs0;

  function automatic logic [15:0] expect_word(input logic [3:0] a);
    return 16'h5A3C ^ {a, ~a, a, 4'hF};
  endfunction

  // Smallest n such that n seconds-per-cycle covers the given nanoseconds.
  function automatic int need_cyc(input longint unsigned ns, input longint unsigned hz);
    longint unsigned n;
    n = (ns * hz) / 64'd1_000_000_000;
    if (n * 64'd1_000_000_000 < ns * hz) n = n + 1;
    if (n == 0) n = 1;
    return int'(n);
  endfunction

  task automatic chk(input logic ok, input string req, input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      finish_run();
    end
  end

  task automatic t_reset_state();
    @(negedge clk);
    chk(!cs0 && !sk0 && !di0 && !busy0 && !done0, "R11 fast idle after reset", {cs0, sk0, di0, busy0}, 0);
    chk(!cs1 && !sk1 && !di1 && !busy1 && !done1, "R11 slow idle after reset", {cs1, sk1, di1, busy1}, 0);
  endtask

  task automatic pulse_start(input logic [3:0] a);
    @(negedge clk);
    addr = a;
    start_req = 1'b1;
    @(negedge clk);
    start_req = 1'b0;
    addr = ~a;
  endtask

  task automatic wait_done(output logic busy_ok);
    int n;
    busy_ok = 1'b1;
    n = 0;
    while (!done_s && n < 20000) begin
      if (!busy_s) busy_ok = 1'b0;
      @(negedge clk);
      n++;
    end
  endtask

  task automatic t_read(input logic s, input logic [3:0] a);
    logic bok;
    logic [15:0] ew;
    sel = s;
    ew = expect_word(a);
    pulse_start(a);
    chk(busy_s, "R9 busy after start", busy_s, 1);
    wait_done(bok);
    chk(done_s, "R9 done reached", done_s, 1);
    chk(bok, "R9 busy held until done", bok, 1);
    chk(word_s == ew, "R6 word", word_s, ew);
    chk(bf_s == ew[15:8], "R8 first byte", bf_s, ew[15:8]);
    chk(bs_s == ew[7:0], "R8 second byte", bs_s, ew[7:0]);
    chk((s ? p1.last_cmd : p0.last_cmd) == (10'h180 | a), "R1 command",
        s ? p1.last_cmd : p0.last_cmd, 10'h180 | a);
    chk((s ? p1.last_rises : p0.last_rises) == 26, "R5 rising edges",
        s ? p1.last_rises : p0.last_rises, 26);
    @(negedge clk);
    chk(!done_s && !busy_s, "R9 done one cycle then idle", {done_s, busy_s}, 0);
    chk(!(s ? cs1 : cs0) && !(s ? sk1 : sk0) && !(s ? di1 : di0), "R11 quiet after access",
        {s ? cs1 : cs0, s ? sk1 : sk0}, 0);
    repeat (3) @(negedge clk);
  endtask

  task automatic t_ignore_start();
    logic bok;
    logic [15:0] ew;
    sel = 1'b0;
    ew = expect_word(4'h6);
    pulse_start(4'h6);
    repeat (400) @(negedge clk);
    pulse_start(4'h9);
    wait_done(bok);
    chk(word_s == ew, "R9 start while busy ignored (word)", word_s, ew);
    chk(p0.last_cmd == 10'h186, "R9 start while busy ignored (command)", p0.last_cmd, 10'h186);
    chk(p0.last_rises == 26, "R9 no restart (edges)", p0.last_rises, 26);
    repeat (3) @(negedge clk);
  endtask

  task automatic t_mid_reset();
    sel = 1'b0;
    pulse_start(4'hC);
    repeat (1200) @(negedge clk);
    chk(cs0 && busy0, "R11 access under way before reset", {cs0, busy0}, 3);
    rst = 1'b1;
    @(negedge clk);
    chk(!cs0 && !sk0 && !di0 && !busy0, "R11 synchronous reset to idle", {cs0, sk0, di0, busy0}, 0);
    @(negedge clk);
    rst = 1'b0;
    repeat (200) @(negedge clk);
    t_read(1'b0, 4'h3);
  endtask

  task automatic t_timing(input logic s, input longint unsigned hz);
    int css, dis, skh, skl, per, csd;
    css = need_cyc(1000, hz); dis = need_cyc(400, hz); skh = need_cyc(1000, hz);
    skl = need_cyc(1000, hz); per = need_cyc(4000, hz); csd = need_cyc(1000, hz);
    chk((s ? p1.min_css : p0.min_css) >= css + dis, "R2 select to first clock",
        s ? p1.min_css : p0.min_css, css + dis);
    chk((s ? p1.min_setup : p0.min_setup) >= dis, "R3 data setup",
        s ? p1.min_setup : p0.min_setup, dis);
    chk((s ? p1.min_hi : p0.min_hi) >= skh, "R4 clock high",
        s ? p1.min_hi : p0.min_hi, skh);
    chk((s ? p1.min_lo : p0.min_lo) >= skl, "R4 clock low",
        s ? p1.min_lo : p0.min_lo, skl);
    chk((s ? p1.min_per : p0.min_per) >= per, "R10 clock period rounded up",
        s ? p1.min_per : p0.min_per, per);
    chk((s ? p1.min_csd : p0.min_csd) >= csd, "R7 deselect time",
        s ? p1.min_csd : p0.min_csd, csd);
  endtask

  initial begin
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset_state();
    t_read(1'b0, 4'h0);
    t_read(1'b0, 4'hF);
    t_read(1'b0, 4'h5);
    t_read(1'b0, 4'hA);
    t_ignore_start();
    t_mid_reset();
    t_read(1'b1, 4'h3);
    t_read(1'b1, 4'hC);
    t_read(1'b1, 4'h7);
    t_timing(1'b0, HZ_FAST);
    t_timing(1'b1, HZ_SLOW);
    finish_run();
  end
endmodule